// File: doc/BRIEF.md
# Strip Cluster Finder with Road Match

This block takes raw hit words from several silicon sensor channels at once. Each channel has its own pipeline. Every hit word carries a strip address and an ADC sample. The pipeline looks the strip up in a per-strip table. If the strip is flagged bad, the hit is dropped. Otherwise the sample is pedestal-subtracted and gain-scaled. A result above a programmable threshold is a hit. Hits on neighbouring strips are merged into clusters. Each closed cluster gets a charge-weighted centroid, and a second per-strip table decides whether that centroid lies inside a seed-track road and, if it does, which road.

Matched clusters from all channels are merged round-robin onto one valid/ready output stream. Each output beat carries the channel, the road index, the centroid, the summed charge and the cluster size. Once every channel has delivered its end-of-event word and all of its clusters, the block emits a single end-of-event beat. A host loads both tables through a simple write port, and that port only takes effect while no event is in progress.

Top module: `strip_cluster_router`

## Requirements
- R1: A table write (`cfg_we`) stores `cfg_word` for strip `cfg_strip` of channel `cfg_ch` only while the block is idle. Idle means no input word has been accepted since the last end-of-event beat left the output. A write while busy changes nothing. The word layout is, from the MSB: mask (1 bit), pedestal (ADC_W), gain (GAIN_W), road-hit flag (1 bit), road index (ROAD_W, in the LSBs).
- R2: A hit word on a strip whose mask bit is 1 is discarded and does not join any cluster, so it leaves a gap.
- R3: The corrected charge is min(2^ADC_W-1, floor(max(adc-pedestal,0)*gain/2^GFRAC)). The gain value 2^GFRAC means unity.
- R4: A corrected charge less than or equal to `thr` counts as no hit.
- R5: Hit words arrive per channel in ascending strip order. A hit on strip last+1 extends the open cluster. A hit on any other strip closes the open cluster and opens a new one. The end-of-event word closes the open cluster.
- R6: A cluster holds at most MAX_SIZE (8) strips. An adjacent hit that would make it larger closes it and starts a new cluster.
- R7: A cluster's output carries the charge sum Σq, the strip count, and the centroid floor(4·Σ(q·strip)/Σq), which is a strip position with two fractional bits.
- R8: The road table entry at strip (centroid+2)>>2 decides the cluster's fate. If its road-hit flag is 0, the cluster is dropped. Otherwise the cluster is output with that entry's road index.
- R9: Clusters from one channel leave in the order they were formed. The channels are served round-robin. A beat stays stable while `out_valid` is high and `out_ready` is low.
- R10: Exactly one end-of-event beat (`out_eoe`=1) is emitted per event. It comes after every channel's end-of-event word has been accepted and all their clusters have left.
- R11: A channel holds `in_ready` low from the acceptance of its end-of-event word until the end-of-event beat has been taken.
- R12: After reset, `out_valid` is 0 and every `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr | input | ADC_W | Hit threshold on corrected charge |
| in_valid | input | NCH | Per-channel word valid |
| in_eoe | input | NCH | Per-channel word is end-of-event marker (no hit) |
| in_strip | input | NCH*STRIP_W | Per-channel strip address |
| in_adc | input | NCH*ADC_W | Per-channel raw ADC sample |
| in_ready | output | NCH | Per-channel word accepted when high with valid |
| cfg_we | input | 1 | Table write strobe |
| cfg_ch | input | CH_W | Table write channel |
| cfg_strip | input | STRIP_W | Table write strip |
| cfg_word | input | 2+ADC_W+GAIN_W+ROAD_W | Table write word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken |
| out_eoe | output | 1 | Beat is the end-of-event marker |
| out_ch | output | CH_W | Source channel |
| out_road | output | ROAD_W | Road index |
| out_cent | output | STRIP_W+2 | Centroid, two fractional bits |
| out_charge | output | ADC_W+SZ_W | Summed corrected charge |
| out_size | output | SZ_W | Strips in cluster |

## Verification
The bench builds the block with four channels and 32 strips per channel, a 3-bit road index, 8-bit samples and unity gain at 64. At this size, writing every table entry is cheap. The correction can also be swept across the whole sample range at several gains and pedestals. Pseudo-random strip patterns cover every channel and every strip under three output back-pressure patterns, so runs longer than eight strips, masked gaps and road misses all occur within a few dozen events.

// File: rtl/scf_pkg.sv
package scf_pkg;

  // Pedestal-subtract, gain-scale, saturate.
  function automatic int unsigned corr_charge(int unsigned adc, int unsigned ped,
                                              int unsigned gain, int unsigned gfrac,
                                              int unsigned qmax);
    int unsigned diff;
    int unsigned prod;
    diff = (adc > ped) ? (adc - ped) : 0;
    prod = (diff * gain) >> gfrac;
    return (prod > qmax) ? qmax : prod;
  endfunction

  // Centroid in quarter strips from first strip and offset-weighted sum.
  function automatic int unsigned cent_fix(int unsigned first, int unsigned sum_qx,
                                           int unsigned sum_q);
    int unsigned den;
    den = (sum_q == 0) ? 1 : sum_q;
    return (first << 2) + ((sum_qx << 2) / den);
  endfunction

  // Nearest whole strip of a quarter-strip position.
  function automatic int unsigned road_strip(int unsigned cent);
    return (cent + 2) >> 2;
  endfunction

  // First requester at or after start, wrapping over n.
  function automatic int unsigned rr_pick(int unsigned req, int unsigned start,
                                          int unsigned n);
    int unsigned pick;
    int unsigned idx;
    pick = start;
    for (int k = 31; k >= 0; k--) begin
      if (k < n) begin
        idx = (start + k) % n;
        if (req[idx]) pick = idx;
      end
    end
    return pick;
  endfunction

endpackage

// File: rtl/scf_table.sv
module scf_table #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scf_channel.sv
module scf_channel
  import scf_pkg::*;
#(
  parameter int STRIP_W  = 7,
  parameter int ADC_W    = 8,
  parameter int GAIN_W   = 8,
  parameter int GFRAC    = 6,
  parameter int ROAD_W   = 4,
  parameter int MAX_SIZE = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADC_W-1:0]       thr,
  input  logic                   in_valid,
  input  logic                   in_eoe,
  input  logic [STRIP_W-1:0]     in_strip,
  input  logic [ADC_W-1:0]       in_adc,
  output logic                   in_ready,
  input  logic                   cfg_we,
  input  logic [STRIP_W-1:0]     cfg_strip,
  input  logic [1+ADC_W+GAIN_W+1+ROAD_W-1:0] cfg_word,
  output logic                   hold_v,
  output logic [ROAD_W+STRIP_W+2+ADC_W+$clog2(MAX_SIZE+1)+$clog2(MAX_SIZE+1)-1:0] hold_pay,
  input  logic                   pop,
  input  logic                   clear_evt,
  output logic                   done,
  output logic                   busy
);
  localparam int SZ_W   = $clog2(MAX_SIZE + 1);
  localparam int SQ_W   = ADC_W + SZ_W;
  localparam int OFF_W  = (MAX_SIZE > 1) ? $clog2(MAX_SIZE) : 1;
  localparam int SQX_W  = SQ_W + OFF_W;
  localparam int CENT_W = STRIP_W + 2;
  localparam int SENT_W = 1 + ADC_W + GAIN_W;
  localparam int RENT_W = 1 + ROAD_W;
  localparam int ENT_W  = SENT_W + RENT_W;
  localparam int QMAX   = (1 << ADC_W) - 1;

  // Tables: strip correction and road membership
  logic [SENT_W-1:0] sent;
  logic [RENT_W-1:0] rent;
  logic [STRIP_W-1:0] rstrip;

  scf_table #(.AW(STRIP_W), .DW(SENT_W)) u_strip_tbl (
    .clk(clk), .we(cfg_we), .waddr(cfg_strip), .wdata(cfg_word[ENT_W-1:RENT_W]),
    .raddr(in_strip), .rdata(sent)
  );

  scf_table #(.AW(STRIP_W), .DW(RENT_W)) u_road_tbl (
    .clk(clk), .we(cfg_we), .waddr(cfg_strip), .wdata(cfg_word[RENT_W-1:0]),
    .raddr(rstrip), .rdata(rent)
  );

  logic               bad;
  logic [ADC_W-1:0]   ped;
  logic [GAIN_W-1:0]  gain;
  assign bad  = sent[SENT_W-1];
  assign ped  = sent[GAIN_W +: ADC_W];
  assign gain = sent[GAIN_W-1:0];

  // Cluster state
  logic               open_q;
  logic [STRIP_W-1:0] first_q, last_q;
  logic [SQ_W-1:0]    sq_q;
  logic [SQX_W-1:0]   sqx_q;
  logic [SZ_W-1:0]    size_q;
  logic               done_q, busy_q;

  logic [ADC_W-1:0]   q;
  logic               hit, adjacent, accept;
  logic               close_evt, start_evt, extend_evt;
  logic [OFF_W-1:0]   off;
  logic [SQX_W-1:0]   qx;
  logic [CENT_W-1:0]  cent;

  assign in_ready = !hold_v && !done_q;
  assign accept   = in_valid && in_ready;

  assign q   = ADC_W'(corr_charge(32'(in_adc), 32'(ped), 32'(gain), GFRAC, QMAX));
  assign hit = !in_eoe && !bad && (q > thr);

  assign adjacent = open_q && (size_q < SZ_W'(MAX_SIZE)) &&
                    ({1'b0, in_strip} == ({1'b0, last_q} + (STRIP_W+1)'(1)));

  assign close_evt  = accept && open_q && (in_eoe || (hit && !adjacent));
  assign start_evt  = accept && hit && !adjacent;
  assign extend_evt = accept && hit && adjacent;

  assign off  = OFF_W'(in_strip - first_q);
  assign qx   = SQX_W'(q) * SQX_W'(off);
  assign cent = CENT_W'(cent_fix(32'(first_q), 32'(sqx_q), 32'(sq_q)));
  assign rstrip = STRIP_W'(road_strip(32'(cent)));

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
      sq_q     <= '0;
      sqx_q    <= '0;
      size_q   <= '0;
      hold_v   <= 1'b0;
      hold_pay <= '0;
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      if (pop) hold_v <= 1'b0;
      if (close_evt && rent[ROAD_W]) begin
        hold_v   <= 1'b1;
        hold_pay <= {rent[ROAD_W-1:0], cent, sq_q, size_q};
      end
      if (start_evt) begin
        open_q  <= 1'b1;
        first_q <= in_strip;
        last_q  <= in_strip;
        sq_q    <= SQ_W'(q);
        sqx_q   <= '0;
        size_q  <= SZ_W'(1);
      end else if (extend_evt) begin
        last_q <= in_strip;
        sq_q   <= sq_q + SQ_W'(q);
        sqx_q  <= sqx_q + qx;
        size_q <= size_q + SZ_W'(1);
      end else if (close_evt) begin
        open_q <= 1'b0;
      end
      if (accept) busy_q <= 1'b1;
      if (accept && in_eoe) done_q <= 1'b1;
      if (clear_evt) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  assign done = done_q;
  assign busy = busy_q;
endmodule

// File: rtl/scf_rr_merge.sv
module scf_rr_merge
  import scf_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3,
  parameter int PW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          req,
  input  logic [NCH-1:0][PW-1:0]  pay,
  input  logic [NCH-1:0]          done,
  output logic [NCH-1:0]          pop,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic                    out_eoe,
  output logic [CH_W-1:0]         out_ch,
  output logic [PW-1:0]           out_pay,
  output logic                    clear_evt
);
  logic            ov_q, oe_q, eoe_sent_q;
  logic [CH_W-1:0] och_q, ptr_q, pick;
  logic [PW-1:0]   op_q;
  logic            load_ok, any_req, eoe_go;

  assign load_ok   = !ov_q || out_ready;
  assign any_req   = |req;
  assign pick      = CH_W'(rr_pick(32'(req), 32'(ptr_q), NCH));
  assign pop       = (load_ok && any_req) ? (NCH'(1) << pick) : '0;
  assign eoe_go    = load_ok && !any_req && (&done) && !eoe_sent_q;
  assign clear_evt = ov_q && oe_q && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q       <= 1'b0;
      oe_q       <= 1'b0;
      eoe_sent_q <= 1'b0;
      och_q      <= '0;
      ptr_q      <= '0;
      op_q       <= '0;
    end else begin
      if (load_ok) begin
        if (any_req) begin
          ov_q  <= 1'b1;
          oe_q  <= 1'b0;
          och_q <= pick;
          op_q  <= pay[pick];
          ptr_q <= (pick == CH_W'(NCH - 1)) ? '0 : pick + 1'b1;
        end else if (eoe_go) begin
          ov_q       <= 1'b1;
          oe_q       <= 1'b1;
          och_q      <= '0;
          op_q       <= '0;
          eoe_sent_q <= 1'b1;
        end else begin
          ov_q <= 1'b0;
          oe_q <= 1'b0;
        end
      end
      if (clear_evt) eoe_sent_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_eoe   = oe_q;
  assign out_ch    = och_q;
  assign out_pay   = op_q;
endmodule

// File: rtl/strip_cluster_router.sv
module strip_cluster_router #(
  parameter int NCH      = 8,
  parameter int STRIP_W  = 7,
  parameter int ADC_W    = 8,
  parameter int GAIN_W   = 8,
  parameter int GFRAC    = 6,
  parameter int ROAD_W   = 4,
  parameter int MAX_SIZE = 8,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SZ_W    = $clog2(MAX_SIZE + 1),
  localparam int SQ_W    = ADC_W + SZ_W,
  localparam int CENT_W  = STRIP_W + 2,
  localparam int ENT_W   = 2 + ADC_W + GAIN_W + ROAD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADC_W-1:0]         thr,
  input  logic [NCH-1:0]           in_valid,
  input  logic [NCH-1:0]           in_eoe,
  input  logic [NCH*STRIP_W-1:0]   in_strip,
  input  logic [NCH*ADC_W-1:0]     in_adc,
  output logic [NCH-1:0]           in_ready,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic [STRIP_W-1:0]       cfg_strip,
  input  logic [ENT_W-1:0]         cfg_word,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_eoe,
  output logic [CH_W-1:0]          out_ch,
  output logic [ROAD_W-1:0]        out_road,
  output logic [CENT_W-1:0]        out_cent,
  output logic [SQ_W-1:0]          out_charge,
  output logic [SZ_W-1:0]          out_size
);
  localparam int PW = ROAD_W + CENT_W + SQ_W + SZ_W;

  logic [NCH-1:0]         hold_v, pop, ch_done, ch_busy;
  logic [NCH-1:0][PW-1:0] hold_pay;
  logic                   clear_evt, idle;
  logic [PW-1:0]          out_pay;

  assign idle = ~|ch_busy;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    scf_channel #(
      .STRIP_W(STRIP_W), .ADC_W(ADC_W), .GAIN_W(GAIN_W), .GFRAC(GFRAC),
      .ROAD_W(ROAD_W), .MAX_SIZE(MAX_SIZE)
    ) u_ch (
      .clk(clk), .rst(rst), .thr(thr),
      .in_valid(in_valid[g]), .in_eoe(in_eoe[g]),
      .in_strip(in_strip[g*STRIP_W +: STRIP_W]),
      .in_adc(in_adc[g*ADC_W +: ADC_W]),
      .in_ready(in_ready[g]),
      .cfg_we(cfg_we && idle && (cfg_ch == CH_W'(g))),
      .cfg_strip(cfg_strip), .cfg_word(cfg_word),
      .hold_v(hold_v[g]), .hold_pay(hold_pay[g]),
      .pop(pop[g]), .clear_evt(clear_evt),
      .done(ch_done[g]), .busy(ch_busy[g])
    );
  end

  scf_rr_merge #(.NCH(NCH), .CH_W(CH_W), .PW(PW)) u_merge (
    .clk(clk), .rst(rst), .req(hold_v), .pay(hold_pay), .done(ch_done),
    .pop(pop), .out_ready(out_ready), .out_valid(out_valid), .out_eoe(out_eoe),
    .out_ch(out_ch), .out_pay(out_pay), .clear_evt(clear_evt)
  );

  assign {out_road, out_cent, out_charge, out_size} = out_pay;
endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
  parameter int NCH      = 8,
  parameter int ADC_W    = 8,
  parameter int MAX_SIZE = 8,
  parameter int CH_W     = 3,
  parameter int ROAD_W   = 4,
  parameter int CENT_W   = 9,
  parameter int SQ_W     = 12,
  parameter int SZ_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADC_W-1:0]  thr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_eoe,
  input logic [CH_W-1:0]   out_ch,
  input logic [ROAD_W-1:0] out_road,
  input logic [CENT_W-1:0] out_cent,
  input logic [SQ_W-1:0]   out_charge,
  input logic [SZ_W-1:0]   out_size,
  input logic [NCH-1:0]    hold_v,
  input logic [NCH-1:0]    pop,
  input logic [NCH-1:0]    ch_done
);
  p_out_stable_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_eoe, out_ch, out_road, out_cent, out_charge, out_size}));

  p_pop_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop) && ((pop & ~hold_v) == '0));

  p_eoe_drained_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eoe |-> (hold_v == '0) && (&ch_done));

  p_size_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eoe |-> (out_size != '0) && (out_size <= SZ_W'(MAX_SIZE)));

  p_charge_thr_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eoe |-> out_charge > {{(SQ_W-ADC_W){1'b0}}, thr});
endmodule

bind strip_cluster_router scf_checker #(
  .NCH(NCH), .ADC_W(ADC_W), .MAX_SIZE(MAX_SIZE), .CH_W(CH_W), .ROAD_W(ROAD_W),
  .CENT_W(CENT_W), .SQ_W(SQ_W), .SZ_W(SZ_W)
) u_chk (
  .clk(clk), .rst(rst), .thr(thr), .out_valid(out_valid), .out_ready(out_ready),
  .out_eoe(out_eoe), .out_ch(out_ch), .out_road(out_road), .out_cent(out_cent),
  .out_charge(out_charge), .out_size(out_size), .hold_v(hold_v), .pop(pop),
  .ch_done(ch_done)
);

// File: tb/sim_strip_cluster_router.sv
module sim_strip_cluster_router;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int SW = 5;
  localparam int NS = 32;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  thr = 0;
  logic [3:0]  in_valid = 0, in_eoe = 0, in_ready;
  logic [19:0] in_strip = 0;
  logic [31:0] in_adc = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_ch = 0;
  logic [4:0]  cfg_strip = 0;
  logic [20:0] cfg_word = 0;
  logic        out_valid, out_ready = 1, out_eoe;
  logic [1:0]  out_ch;
  logic [2:0]  out_road;
  logic [6:0]  out_cent;
  logic [11:0] out_charge;
  logic [3:0]  out_size;

  strip_cluster_router #(.NCH(NC), .STRIP_W(SW), .ADC_W(8), .GAIN_W(8), .GFRAC(6),
                         .ROAD_W(3), .MAX_SIZE(8)) u0 (
    .clk(clk), .rst(rst), .thr(thr), .in_valid(in_valid), .in_eoe(in_eoe),
    .in_strip(in_strip), .in_adc(in_adc), .in_ready(in_ready), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_strip(cfg_strip), .cfg_word(cfg_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_eoe(out_eoe), .out_ch(out_ch),
    .out_road(out_road), .out_cent(out_cent), .out_charge(out_charge), .out_size(out_size)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int b_mask [NC][NS], b_ped [NC][NS], b_gain [NC][NS], b_rhit [NC][NS], b_ridx [NC][NS];
  int ev_s [NC][NS], ev_a [NC][NS], ev_n [NC];
  int e_road [NC][NS], e_cent [NC][NS], e_q [NC][NS], e_sz [NC][NS], exp_n [NC];
  int thr_v = 0;
  string cur_req = "R3";
  int lfsr = 32'h1234abcd;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr & 32'h7fffffff;
  endfunction

  function automatic int bcorr(input int adc, input int ped, input int gain);
    int d;
    d = adc - ped;
    if (d < 0) d = 0;
    d = (d * gain) / 64;
    if (d > 255) d = 255;
    return d;
  endfunction

  // R1 layout: {mask, ped, gain, road_hit, road_idx}
  function automatic logic [20:0] pk(input int ch, input int s, input int force_mask);
    return {(b_mask[ch][s] != 0) || (force_mask != 0), 8'(b_ped[ch][s]), 8'(b_gain[ch][s]),
            1'(b_rhit[ch][s]), 3'(b_ridx[ch][s])};
  endfunction

  task automatic wr(input int ch, input int s);
    cfg_ch = 2'(ch); cfg_strip = 5'(s); cfg_word = pk(ch, s, 0); cfg_we = 1;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic clr_ev();
    for (int c = 0; c < NC; c++) ev_n[c] = 0;
  endtask

  task automatic add_hit(input int ch, input int s, input int a);
    ev_s[ch][ev_n[ch]] = s; ev_a[ch][ev_n[ch]] = a; ev_n[ch]++;
  endtask

  task automatic emit(input int ch, input int sq, input int sqs, input int sz);
    int cent, rs;
    cent = (4 * sqs) / sq;
    rs = (cent + 2) / 4;
    if (b_rhit[ch][rs] != 0) begin
      e_road[ch][exp_n[ch]] = b_ridx[ch][rs];
      e_cent[ch][exp_n[ch]] = cent;
      e_q[ch][exp_n[ch]] = sq;
      e_sz[ch][exp_n[ch]] = sz;
      exp_n[ch]++;
    end
  endtask

  task automatic build_exp(input int ch);
    int open, last, sz, sq, sqs, s, q;
    open = 0; last = 0; sz = 0; sq = 0; sqs = 0;
    exp_n[ch] = 0;
    for (int k = 0; k < ev_n[ch]; k++) begin
      s = ev_s[ch][k];
      q = bcorr(ev_a[ch][k], b_ped[ch][s], b_gain[ch][s]);
      if (b_mask[ch][s] == 0 && q > thr_v) begin
        if (open != 0 && s == last + 1 && sz < 8) begin
          sq += q; sqs += q * s; sz++; last = s;
        end else begin
          if (open != 0) emit(ch, sq, sqs, sz);
          open = 1; sq = q; sqs = q * s; sz = 1; last = s;
        end
      end
    end
    if (open != 0) emit(ch, sq, sqs, sz);
  endtask

  task automatic run_event(input int bp, input bit busy_wr, input bit rr_test);
    int idx [NC];
    int got [NC];
    int bch [4];
    int nb, cyc, c;
    bit seen, stall;
    logic [28:0] snap, beat;
    for (int ch = 0; ch < NC; ch++) begin
      build_exp(ch); idx[ch] = 0; got[ch] = 0;
    end
    nb = 0; cyc = 0; seen = 0; stall = 0; snap = '0;
    while (!seen && cyc < 3000) begin
      for (int ch = 0; ch < NC; ch++) begin
        in_valid[ch] = (idx[ch] <= ev_n[ch]);
        in_eoe[ch] = (idx[ch] == ev_n[ch]);
        in_strip[ch*5 +: 5] = (idx[ch] < ev_n[ch]) ? 5'(ev_s[ch][idx[ch]]) : 5'd0;
        in_adc[ch*8 +: 8] = (idx[ch] < ev_n[ch]) ? 8'(ev_a[ch][idx[ch]]) : 8'd0;
      end
      out_ready = (bp == 0) ? 1'b1 : (bp == 1) ? ((cyc % 3) != 0) : ((cyc % 4) == 0);
      if (busy_wr && cyc == 2) begin
        cfg_ch = 0; cfg_strip = 5; cfg_word = pk(0, 5, 1); cfg_we = 1;
      end else cfg_we = 0;
      @(negedge clk);
      beat = {out_eoe, out_ch, out_road, out_cent, out_charge, out_size};
      if (stall) chk(out_valid && beat == snap, "R9", int'(beat), int'(snap));
      stall = out_valid && !out_ready;
      snap = beat;
      for (int ch = 0; ch < NC; ch++)
        if (idx[ch] > ev_n[ch]) chk(!in_ready[ch], "R11", in_ready[ch], 0);
      if (out_valid && out_ready) begin
        if (out_eoe) begin
          seen = 1;
          for (int ch = 0; ch < NC; ch++) chk(got[ch] == exp_n[ch], "R10", got[ch], exp_n[ch]);
        end else begin
          c = int'(out_ch);
          if (nb < 4) bch[nb] = c;
          nb++;
          if (got[c] < exp_n[c]) begin
            chk(out_road == 3'(e_road[c][got[c]]), "R8", out_road, e_road[c][got[c]]);
            chk(out_cent == 7'(e_cent[c][got[c]]), "R7", out_cent, e_cent[c][got[c]]);
            chk(out_charge == 12'(e_q[c][got[c]]), cur_req, out_charge, e_q[c][got[c]]);
            chk(out_size == 4'(e_sz[c][got[c]]), "R6", out_size, e_sz[c][got[c]]);
          end else chk(0, "R5", got[c] + 1, exp_n[c]);
          got[c]++;
        end
      end
      for (int ch = 0; ch < NC; ch++)
        if (in_valid[ch] && in_ready[ch]) idx[ch]++;
      @(posedge clk); #1;
      cyc++;
    end
    cfg_we = 0;
    in_valid = 0; in_eoe = 0; out_ready = 1;
    if (!seen) chk(0, "R10", cyc, 0);
    if (rr_test) begin
      chk(nb >= 4, "R9", nb, 4);
      for (int i = 0; i < 4; i++)
        for (int j = i + 1; j < 4; j++)
          chk(bch[i] != bch[j], "R9", bch[i], bch[j] + 100);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int gains [4];
    int cnt;
    gains[0] = 64; gains[1] = 32; gains[2] = 100; gains[3] = 200;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid, "R12", out_valid, 0);
    chk(in_ready == 4'hf, "R12", in_ready, 15);
    @(posedge clk); #1;

    // Baseline tables (R1: idle writes take effect)
    for (int ch = 0; ch < NC; ch++)
      for (int s = 0; s < NS; s++) begin
        b_mask[ch][s] = 0; b_ped[ch][s] = 0; b_gain[ch][s] = 64;
        b_rhit[ch][s] = 1; b_ridx[ch][s] = (s >> 2) ^ ch;
        wr(ch, s);
      end

    // R3: correction sweep on channel 0 strip 5
    cur_req = "R3";
    thr = 0; thr_v = 0;
    for (int g = 0; g < 4; g++)
      for (int p = 0; p < 2; p++) begin
        b_gain[0][5] = gains[g]; b_ped[0][5] = p * 20;
        wr(0, 5);
        for (int a = 0; a < 256; a += 5) begin
          clr_ev(); add_hit(0, 5, a);
          run_event(0, 0, 0);
        end
      end
    b_gain[0][5] = 64; b_ped[0][5] = 0; wr(0, 5);

    // R4: threshold boundary
    cur_req = "R4";
    thr = 30; thr_v = 30;
    for (int a = 26; a <= 34; a++) begin
      clr_ev(); add_hit(1, 7, a); add_hit(2, 3, a + 1);
      run_event(0, 0, 0);
    end

    // R2: masked strip splits a run
    cur_req = "R2";
    thr = 10; thr_v = 10;
    b_mask[1][9] = 1; wr(1, 9);
    clr_ev(); add_hit(1, 8, 50); add_hit(1, 9, 200); add_hit(1, 10, 70);
    run_event(0, 0, 0);
    chk(exp_n[1] == 2, "R2", exp_n[1], 2);

    // R6: long run splits at eight strips
    cur_req = "R6";
    clr_ev();
    for (int s = 0; s < 20; s++) add_hit(2, s, 40 + 7 * s);
    run_event(1, 0, 0);
    chk(exp_n[2] == 3, "R6", exp_n[2], 3);

    // R9: four channels with simultaneous clusters
    cur_req = "R9";
    clr_ev();
    for (int ch = 0; ch < NC; ch++) begin
      add_hit(ch, 2, 60); add_hit(ch, 6, 61); add_hit(ch, 10, 62);
    end
    run_event(0, 0, 1);

    // R1: write while busy is ignored
    cur_req = "R1";
    clr_ev(); add_hit(0, 0, 90); add_hit(0, 1, 90); add_hit(0, 2, 90); add_hit(0, 3, 90);
    run_event(1, 1, 0);
    clr_ev(); add_hit(0, 5, 100);
    run_event(0, 0, 0);
    chk(exp_n[0] == 1, "R1", exp_n[0], 1);

    // R10: empty event gives just the marker
    clr_ev();
    run_event(0, 0, 0);

    // R8: road misses on channel 3, odd tables elsewhere
    for (int s = 12; s < 16; s++) begin b_rhit[3][s] = 0; wr(3, s); end
    b_ped[2][20] = 40; b_gain[2][20] = 150; wr(2, 20);

    // R5/R7: pseudo-random patterns with back-pressure
    cur_req = "R5";
    thr = 15; thr_v = 15;
    cnt = 0;
    for (int e = 0; e < 36; e++) begin
      clr_ev();
      for (int ch = 0; ch < NC; ch++)
        for (int s = 0; s < NS; s++) begin
          int r;
          r = rnd();
          if ((r % 3) != 0) add_hit(ch, s, (r >> 8) & 255);
        end
      run_event(e % 3, 0, 0);
      for (int ch = 0; ch < NC; ch++) cnt += exp_n[ch];
    end
    chk(cnt > 100, "R5", cnt, 101);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule